// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This unit moves a group of registers between a 16-entry register file and word-addressed memory, one word per cycle. A 16-bit mask picks the registers. The unit walks the mask from the lowest index to the highest, so register 0 lands at the lowest address and the register at the top index lands at the highest. The caller supplies the operation, the base register index, the base value and a writeback enable on a one-cycle `start` pulse. `done` then pulses once when the sequence is complete.

Five operations are offered:
- upward load;
- upward store;
- downward store;
- stack pop;
- stack push.

The two stack operations always use register 13 as the base and always update it. A downward store first lowers the address by four times the number of selected registers, then stores upward from there. Loading the top register does not write the register file: it raises a separate program-counter write strobe. Two flags mark the cases where an architecturally undefined value would be produced. These are a stored base register that is not the first one moved, and a loaded base register combined with writeback.

Top module: `lsm_seq`

## Requirements
- R1: Selected registers are moved in ascending index order. Each accepted access is followed by the next request at an address 4 higher.
- R2: The first address equals `base_val` for op 0 (upward load), op 1 (upward store) and op 3 (pop). It equals `base_val` − 4 × (number of set mask bits) for op 2 (downward store) and op 4 (push).
- R3: Register 15 is moved after every lower register. When it is loaded, `pc_we` pulses with the memory word and `rf_we` stays low in that cycle.
- R4: With writeback on and a non-empty mask, the cycle after the last accepted access writes the base register (`base_idx`) through the register port. The value written is base + 4 × count for upward operations and base − 4 × count for downward ones.
- R5: On a store with writeback, `mem_wdata_unk` is high exactly when the register being stored is the base register and it is not the lowest set bit of the mask.
- R6: On a load with writeback, the base writeback carries `rf_wdata_unk` = 1 exactly when the base register is selected in the mask.
- R7: Op 3 (pop) and op 4 (push) use register 13 as base and always write it back, whatever the values of `base_idx` and `wback`.
- R8: An empty mask raises `done` in the cycle after `start`, with no memory request and no register or program-counter write.
- R9: While `mem_ready` is low, `mem_req`, `mem_addr` and the register selection are held, and no register or program-counter write occurs.
- R10: `done` is high for one cycle, in the cycle after the final action (the last access, or the writeback when there is one), and `busy` is low in that cycle.
- R11: After reset, `busy`, `done`, `mem_req`, `rf_we` and `pc_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (accepted while idle) |
| op | input | 3 | 0 upward load, 1 upward store, 2 downward store, 3 pop, 4 push |
| base_idx | input | 4 | Base register index (ignored for pop and push) |
| wback | input | 1 | Update the base at the end (forced on for pop and push) |
| reg_mask | input | 16 | Registers to move, bit i selects register i |
| base_val | input | 32 | Current value of the base register |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Store data |
| mem_wdata_unk | output | 1 | Store data is architecturally undefined |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Load data, valid in the accepting cycle |
| rf_raddr | output | 4 | Register file read index |
| rf_rdata | input | 32 | Register file read data |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 4 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| rf_wdata_unk | output | 1 | Write data is architecturally undefined |
| pc_we | output | 1 | Program counter write strobe |
| pc_wdata | output | 32 | Program counter write data |

## Verification
A corrupted remaining-mask bit shows up at the ports within one cycle. It appears either as a wrong register index on the next accepted access, or as an access count that differs from the mask population, which then moves `done` or the writeback to the wrong cycle. A wrong address register shows on the very next request, and it keeps showing on every later one, because the address only ever advances by four. The two undefined-value flags and the writeback value depend only on state latched at `start`. An error there appears in the affected store cycle, or in the single writeback cycle.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [2:0] {
    OP_LOAD_UP     = 3'd0,
    OP_STORE_UP    = 3'd1,
    OP_STORE_DOWN  = 3'd2,
    OP_STACK_POP   = 3'd3,
    OP_STACK_PUSH  = 3'd4
  } lsm_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_WB   = 2'd2
  } lsm_state_e;
endpackage

// File: rtl/lsm_popcnt.sv
module lsm_popcnt #(
  parameter int N = 16,
  localparam int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) begin
      cnt = cnt + CW'(vec[i]);
    end
  end
endmodule

// File: rtl/lsm_first_set.sv
module lsm_first_set #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx
);
  // Lowest set bit wins; scanning downward leaves the lowest index last.
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq #(
  parameter int NREG   = 16,
  parameter int DW     = 32,
  parameter int STEP   = 4,
  parameter int SP_IDX = 13,
  localparam int IW    = $clog2(NREG),
  localparam int CW    = $clog2(NREG + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2:0]      op,
  input  logic [IW-1:0]   base_idx,
  input  logic            wback,
  input  logic [NREG-1:0] reg_mask,
  input  logic [DW-1:0]   base_val,
  output logic            busy,
  output logic            done,
  output logic            mem_req,
  output logic            mem_we,
  output logic [DW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_wdata_unk,
  input  logic            mem_ready,
  input  logic [DW-1:0]   mem_rdata,
  output logic [IW-1:0]   rf_raddr,
  input  logic [DW-1:0]   rf_rdata,
  output logic            rf_we,
  output logic [IW-1:0]   rf_waddr,
  output logic [DW-1:0]   rf_wdata,
  output logic            rf_wdata_unk,
  output logic            pc_we,
  output logic [DW-1:0]   pc_wdata
);
  import lsm_pkg::*;

  localparam logic [IW-1:0] PC_ID = IW'(NREG - 1);
  localparam logic [IW-1:0] SP_ID = IW'(SP_IDX);

  lsm_state_e      state_q, state_d;
  logic [NREG-1:0] rem_q, rem_d;
  logic [DW-1:0]   addr_q, addr_d;
  logic            done_q, done_d;
  logic            cfg_en;

  logic [DW-1:0]   wbval_q;
  logic [IW-1:0]   base_q, first_q;
  logic            load_q, wb_q, base_in_q;

  // Decode of the request presented with start.
  logic            dec_load, dec_down, dec_wb;
  logic [IW-1:0]   dec_base;
  logic [CW-1:0]   sel_cnt;
  logic [IW-1:0]   mask_first, cur;
  logic [DW-1:0]   span, start_addr, end_base;

  always_comb begin
    dec_load = 1'b0;
    dec_down = 1'b0;
    dec_base = base_idx;
    dec_wb   = wback;
    case (lsm_op_e'(op))
      OP_STORE_UP:   ;
      OP_STORE_DOWN: dec_down = 1'b1;
      OP_STACK_POP:  begin dec_load = 1'b1; dec_base = SP_ID; dec_wb = 1'b1; end
      OP_STACK_PUSH: begin dec_down = 1'b1; dec_base = SP_ID; dec_wb = 1'b1; end
      default:       dec_load = 1'b1;
    endcase
  end

  lsm_popcnt #(.N(NREG)) u_cnt (.vec(reg_mask), .cnt(sel_cnt));
  lsm_first_set #(.N(NREG)) u_first (.vec(reg_mask), .idx(mask_first));
  lsm_first_set #(.N(NREG)) u_next  (.vec(rem_q),    .idx(cur));

  assign span       = DW'(sel_cnt) * DW'(STEP);
  assign start_addr = dec_down ? (base_val - span) : base_val;
  assign end_base   = dec_down ? (base_val - span) : (base_val + span);

  // Next-state logic.
  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    addr_d  = addr_q;
    done_d  = 1'b0;
    cfg_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          cfg_en = 1'b1;
          rem_d  = reg_mask;
          addr_d = start_addr;
          if (reg_mask == '0) done_d  = 1'b1;
          else                state_d = ST_XFER;
        end
      end
      ST_XFER: begin
        if (mem_ready) begin
          rem_d  = rem_q & ~(NREG'(1) << cur);
          addr_d = addr_q + DW'(STEP);
          if (rem_d == '0) begin
            if (wb_q) state_d = ST_WB;
            else begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end
          end
        end
      end
      ST_WB: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Control registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      done_q  <= done_d;
    end
  end

  // Datapath registers, no reset.
  always_ff @(posedge clk) begin
    addr_q <= addr_d;
    if (cfg_en) begin
      wbval_q   <= end_base;
      base_q    <= dec_base;
      first_q   <= mask_first;
      load_q    <= dec_load;
      wb_q      <= dec_wb;
      base_in_q <= reg_mask[dec_base];
    end
  end

  // Outputs.
  logic in_xfer, in_wb;
  assign in_xfer = (state_q == ST_XFER);
  assign in_wb   = (state_q == ST_WB);

  assign busy          = (state_q != ST_IDLE);
  assign done          = done_q;
  assign mem_req       = in_xfer;
  assign mem_we        = in_xfer && !load_q;
  assign mem_addr      = addr_q;
  assign rf_raddr      = cur;
  assign mem_wdata     = rf_rdata;
  assign mem_wdata_unk = in_xfer && !load_q && wb_q && (cur == base_q) && (cur != first_q);
  assign rf_we         = (in_xfer && load_q && mem_ready && (cur != PC_ID)) || in_wb;
  assign rf_waddr      = in_wb ? base_q : cur;
  assign rf_wdata      = in_wb ? wbval_q : mem_rdata;
  assign rf_wdata_unk  = in_wb && load_q && base_in_q;
  assign pc_we         = in_xfer && load_q && mem_ready && (cur == PC_ID);
  assign pc_wdata      = mem_rdata;
endmodule

// File: rtl/lsm_seq_chk.sv
module lsm_seq_chk #(
  parameter int DW   = 32,
  parameter int STEP = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ready,
  input logic [DW-1:0] mem_addr,
  input logic          mem_wdata_unk,
  input logic          rf_we,
  input logic          pc_we,
  input logic          rf_wdata_unk
);
  assert_addr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready) |=> (!mem_req || (mem_addr == $past(mem_addr) + DW'(STEP))));

  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

  assert_no_write_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |-> (!rf_we && !pc_we));

  assert_pc_strobe_alone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |-> (!rf_we && mem_req && !mem_we && mem_ready));

  assert_unk_store_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wdata_unk |-> (mem_req && mem_we));

  assert_unk_wb_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wdata_unk |-> (rf_we && !mem_req));

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !mem_req));
endmodule

bind lsm_seq lsm_seq_chk #(.DW(DW), .STEP(STEP)) u_lsm_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_wdata_unk(mem_wdata_unk),
  .rf_we(rf_we), .pc_we(pc_we), .rf_wdata_unk(rf_wdata_unk)
);

// File: tb/lsm_seq_test.sv
module lsm_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [2:0]  op;
  logic [3:0]  base_idx;
  logic        wback;
  logic [15:0] reg_mask;
  logic [31:0] base_val;
  logic        busy, done, mem_req, mem_we, mem_wdata_unk, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rdata, rf_wdata, pc_wdata;
  logic [3:0]  rf_raddr, rf_waddr;
  logic        rf_we, rf_wdata_unk, pc_we;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  logic [7:0] lfsr = 8'h5B;
  logic stall_en = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] reg_val(input logic [3:0] i);
    return 32'hA000_0011 + (32'(i) << 8);
  endfunction
  function automatic logic [31:0] mem_val(input logic [31:0] a);
    return 32'h5000_0000 + (a >> 2);
  endfunction

  assign rf_rdata  = reg_val(rf_raddr);
  assign mem_rdata = mem_val(mem_addr);

  lsm_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .base_idx(base_idx),
    .wback(wback), .reg_mask(reg_mask), .base_val(base_val), .busy(busy),
    .done(done), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wdata_unk(mem_wdata_unk), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .rf_wdata_unk(rf_wdata_unk), .pc_we(pc_we), .pc_wdata(pc_wdata)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        n_bad++;
        $display("FAIL R10 watchdog actual=hang expected=done");
        finish_run();
      end
    end
  end

  task automatic run_seq(input logic [2:0] op_i, input logic [3:0] bidx_i,
                         input logic wb_i, input logic [15:0] mask_i,
                         input logic [31:0] base_i);
    logic ld, dn, wbe;
    logic [3:0] bidx;
    int cnt, lowest, nxt, k;
    logic [31:0] a, nb;
    ld = (op_i == 3'd0) || (op_i == 3'd3);
    dn = (op_i == 3'd2) || (op_i == 3'd4);
    wbe = (op_i >= 3'd3) ? 1'b1 : wb_i;
    bidx = (op_i >= 3'd3) ? 4'd13 : bidx_i;
    cnt = 0; lowest = -1;
    for (int i = 0; i < 16; i++) if (mask_i[i]) begin
      cnt++;
      if (lowest < 0) lowest = i;
    end
    a  = dn ? base_i - 32'(4 * cnt) : base_i;
    nb = dn ? base_i - 32'(4 * cnt) : base_i + 32'(4 * cnt);

    @(negedge clk);
    op = op_i; base_idx = bidx_i; wback = wb_i; reg_mask = mask_i;
    base_val = base_i; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    nxt = 0; k = 0;
    while (k < cnt) begin
      while (!mask_i[nxt]) nxt++;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_ready = !stall_en || lfsr[0] || lfsr[3];
      #1;
      check(mem_req, 1, "R1 request");
      check(mem_addr, a, (k == 0) ? "R2 first address" : "R1 address step");
      check(mem_we, !ld, "R1 direction");
      if (mem_ready) begin
        if (ld) begin
          if (nxt == 15) begin
            check(pc_we, 1, "R3 pc strobe");
            check(rf_we, 0, "R3 no reg write");
            check(pc_wdata, mem_val(a), "R3 pc data");
          end else begin
            check(pc_we, 0, "R3 pc idle");
            check(rf_we, 1, "R1 reg write");
            check(rf_waddr, 32'(nxt), "R1 load order");
            check(rf_wdata, mem_val(a), "R1 load data");
          end
        end else begin
          check(mem_wdata, reg_val(4'(nxt)), "R1 store order");
          check(mem_wdata_unk, (wbe && (4'(nxt) == bidx) && (nxt != lowest)), "R5 unknown store");
        end
        a = a + 32'd4;
        nxt++;
        k++;
      end else begin
        check(rf_we | pc_we, 0, "R9 no write while stalled");
      end
      @(negedge clk);
    end
    mem_ready = 1'b1;
    if (cnt > 0 && wbe) begin
      #1;
      check(rf_we, 1, (op_i >= 3'd3) ? "R7 stack writeback" : "R4 writeback");
      check(rf_waddr, 32'(bidx), (op_i >= 3'd3) ? "R7 stack base" : "R4 base index");
      check(rf_wdata, nb, "R4 writeback value");
      check(rf_wdata_unk, ld && mask_i[bidx], "R6 unknown base");
      check(done, 0, "R10 done timing");
      @(negedge clk);
    end
    #1;
    check(done, 1, (cnt == 0) ? "R8 empty done" : "R10 done pulse");
    check(busy, 0, "R10 idle at done");
    check(mem_req, 0, (cnt == 0) ? "R8 no access" : "R10 no access");
    check(rf_we | pc_we, 0, (cnt == 0) ? "R8 no write" : "R10 no write");
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; op = 3'd0; base_idx = 4'd0; wback = 1'b0;
    reg_mask = 16'h0; base_val = 32'h0; mem_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(busy, 0, "R11 busy");
    check(done, 0, "R11 done");
    check(mem_req, 0, "R11 req");
    check(rf_we, 0, "R11 rf_we");
    check(pc_we, 0, "R11 pc_we");
    rst_n = 1'b1;

    // Directed corner cases.
    run_seq(3'd1, 4'd2, 1'b1, 16'h0006, 32'h80);  // R5 base not lowest
    run_seq(3'd1, 4'd1, 1'b1, 16'h0006, 32'h80);  // R5 base is lowest
    run_seq(3'd0, 4'd3, 1'b1, 16'h8008, 32'h80);  // R6 and R3
    run_seq(3'd3, 4'd0, 1'b0, 16'hA001, 32'h80);  // R7 pop with 13 and 15
    run_seq(3'd4, 4'd0, 1'b0, 16'h4010, 32'h80);  // R7 push
    run_seq(3'd2, 4'd5, 1'b0, 16'h0000, 32'h80);  // R8 empty
    run_seq(3'd4, 4'd5, 1'b1, 16'h0000, 32'h80);  // R8 empty stack

    // Sweep every operation over one-hot masks and rotated patterns, with stalls.
    for (int s = 0; s < 2; s++) begin
      stall_en = (s == 1);
      for (int o = 0; o < 5; o++) begin
        for (int j = 0; j < 16; j++) begin
          run_seq(3'(o), 4'(j % 15), 1'(j), 16'(1) << j, 32'h80);
          run_seq(3'(o), 4'((j + 5) % 15), 1'(j + 1),
                  16'((32'hA5A5A5A5 >> j) & 32'hFFFF), 32'h80);
        end
        run_seq(3'(o), 4'd7, 1'b1, 16'hFFFF, 32'h80);
      end
    end
    finish_run();
  end
endmodule